// File: doc/BRIEF.md
# Byte-lane DRAM access controller

This block sits between a synchronous host port and an asynchronous dynamic RAM that takes its address in two halves and has one column strobe for each byte of its 16-bit word. For each host request it runs one complete memory cycle. It presents the row half of the address, drops the row strobe, then switches to the column half and drops the column strobes. For a read it waits until every access delay has elapsed and captures the word. Finally it returns both strobe groups high and observes the precharge gaps before it takes another request.

The host holds a request with its address, write flag, data and two byte enables until it sees a one-clock acknowledge. A byte access drops only the column strobe of the selected byte. Every minimum timing of the memory is a parameter counted in clock cycles. The data bus is split into an output word, an output enable and an input word, which are joined into a tristate bus outside this block.

Top module: `bytelane_dram_ctrl`

## Requirements
- R1: The row half `hostAddr[15:8]` is on `dramAddr` when the row strobe falls. The column half `hostAddr[7:0]` is on `dramAddr` when a column strobe falls, and it stays there until the row strobe rises.
- R2: Byte enable bit 0 selects the lower strobe and data bits 7:0. Bit 1 selects the upper strobe and bits 15:8. An enable of 2'b00 is treated as 2'b11. Only the strobes of enabled lanes fall.
- R3: A column strobe is low only while the row strobe is low. After reset all strobes, the write enable and the output enable are high, and the bus enable and the acknowledge are low.
- R4: The row strobe stays low for at least `T_RAS` cycles once it falls.
- R5: Before the row strobe falls, it has been high for at least `T_RP` cycles. Before a column strobe falls, both column strobes have been high for at least `T_CP` cycles. Requests are not accepted before these gaps are met.
- R6: A read keeps the write enable high and drops the output enable on the same edge as the column strobes. The read word is captured only when at least `T_RAC` cycles have passed since the row strobe fell, `T_CAC` and `T_OE` cycles since the column and output strobes fell, and `T_AA` cycles since the column address was applied.
- R7: A write drops the write enable on the same edge as the column strobes. The write word is driven on the bus at least one cycle before that edge.
- R8: The row strobe stays low for at least `T_AR` cycles after it falls, so the column address is held for that long.
- R9: The bus output enable is high only during a write cycle.
- R10: The acknowledge is high for exactly one cycle, on the edge where the column strobes rise. For a read, `hostRdata` carries the word in that same cycle, with the bytes of disabled lanes reading as zero.
- R11: The row strobe falls at least `T_RCD` cycles before the column strobes fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Request, held until acknowledge |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 16 | Word address: row in 15:8, column in 7:0 |
| hostWdata | input | 16 | Write word |
| hostBe | input | 2 | Byte enables (bit 0 lower byte) |
| hostAck | output | 1 | One-cycle completion pulse |
| hostRdata | output | 16 | Read word, valid with acknowledge |
| dramRowStrobeN | output | 1 | Row strobe, active low |
| dramLoStrobeN | output | 1 | Lower-byte column strobe, active low |
| dramHiStrobeN | output | 1 | Upper-byte column strobe, active low |
| dramWrEnN | output | 1 | Write enable, active low |
| dramOutEnN | output | 1 | Memory output enable, active low |
| dramAddr | output | 8 | Multiplexed row/column address |
| dramDqOut | output | 16 | Word driven onto the bus |
| dramDqOe | output | 1 | Bus drive enable |
| dramDqIn | input | 16 | Word read from the bus |

## Verification
A timing counter that is off by one, or a wrong state, shows within one memory cycle as a strobe edge that comes too early. It also shows as a wrong address sampled at a strobe edge or as a strobe on a disabled lane. A read captured before the memory's delays have all elapsed returns a filler pattern, not the stored word. The acknowledge for that access then shows the mismatch on `hostRdata`. A lane masking or write path fault corrupts the stored word, and a sweep over every address and byte-enable combination reads that word back later.

// File: rtl/bldc_pkg.sv
package bldc_pkg;

  typedef struct packed {
    logic latchReq;
    logic selCol;
    logic capture;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROWSET,
    ST_RCDWAIT,
    ST_COLSET,
    ST_ACCESS,
    ST_RELEASE
  } ctrlState_t;

endpackage

// File: rtl/bldc_dpath.sv
module bldc_dpath import bldc_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [1:0]        hostBe,
  input  logic [DATA_W-1:0] dramDqIn,
  output logic [ADDR_W/2-1:0] dramAddr,
  output logic [DATA_W-1:0] dramDqOut,
  output logic [DATA_W-1:0] hostRdata,
  output logic              curWrite,
  output logic [1:0]        laneMask
);
  localparam int HALF   = ADDR_W / 2;
  localparam int LANE_W = DATA_W / 2;

  logic [HALF-1:0]   colReg;
  logic [HALF-1:0]   addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdataReg;
  logic              wrReg;
  logic [1:0]        maskReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colReg   <= '0;
      addrReg  <= '0;
      wdataReg <= '0;
      wrReg    <= 1'b0;
      maskReg  <= 2'b00;
    end else if (strobe.latchReq) begin
      colReg   <= hostAddr[HALF-1:0];
      addrReg  <= hostAddr[ADDR_W-1:HALF];
      wdataReg <= hostWdata;
      wrReg    <= hostWe;
      maskReg  <= (hostBe == 2'b00) ? 2'b11 : hostBe;
    end else if (strobe.selCol) begin
      addrReg  <= colReg;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN)
        rdataReg[g*LANE_W +: LANE_W] <= '0;
      else if (strobe.capture)
        rdataReg[g*LANE_W +: LANE_W] <= maskReg[g] ? dramDqIn[g*LANE_W +: LANE_W] : '0;
    end
  end

  assign dramAddr  = addrReg;
  assign dramDqOut = wdataReg;
  assign hostRdata = rdataReg;
  assign curWrite  = wrReg;
  assign laneMask  = maskReg;

  // R2
  lane_mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.latchReq) |-> (maskReg != 2'b00));

endmodule

// File: rtl/bldc_ctrl.sv
module bldc_ctrl import bldc_pkg::*; #(
  parameter int T_RAS = 6,
  parameter int T_RP  = 3,
  parameter int T_CP  = 2,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_RAC = 5,
  parameter int T_CAC = 2,
  parameter int T_AA  = 3,
  parameter int T_OE  = 2,
  parameter int T_AR  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostReq,
  input  logic       curWrite,
  input  logic [1:0] laneMask,
  output dpStrobe_t  strobe,
  output logic       rasN,
  output logic       loN,
  output logic       hiN,
  output logic       weN,
  output logic       oeN,
  output logic       dqOe,
  output logic       hostAck
);
  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_MAX = maxOf(maxOf(maxOf(T_RAS, T_RP), maxOf(T_CP, T_RCD)),
                               maxOf(maxOf(T_CAS, T_RAC), maxOf(maxOf(T_CAC, T_AA),
                                     maxOf(T_OE, T_AR))));
  localparam int CNT_W = $clog2(T_MAX + 2) + 1;
  localparam logic [CNT_W-1:0] CMAX  = '1;
  localparam logic [CNT_W-1:0] L_RAS = CNT_W'(T_RAS);
  localparam logic [CNT_W-1:0] L_RP  = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] L_CP  = CNT_W'(T_CP);
  localparam logic [CNT_W-1:0] L_RCD = CNT_W'(T_RCD);
  localparam logic [CNT_W-1:0] L_CAS = CNT_W'(T_CAS);
  localparam logic [CNT_W-1:0] L_RAC = CNT_W'(T_RAC);
  localparam logic [CNT_W-1:0] L_CAC = CNT_W'(T_CAC);
  localparam logic [CNT_W-1:0] L_AA  = CNT_W'(T_AA);
  localparam logic [CNT_W-1:0] L_OE  = CNT_W'(T_OE);
  localparam logic [CNT_W-1:0] L_AR  = CNT_W'(T_AR);

  function automatic logic [CNT_W-1:0] satInc(input logic [CNT_W-1:0] v);
    return (v == CMAX) ? v : v + 1'b1;
  endfunction

  // true when a span whose counter reads v (first cycle = 0) covers d cycles
  function automatic logic reached(input logic [CNT_W-1:0] v, input logic [CNT_W-1:0] d);
    return ({1'b0, v} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, d};
  endfunction

  ctrlState_t state, nextState;
  logic [CNT_W-1:0] rasLowCnt, rasHighCnt, casLowCnt, casHighCnt, colAge;
  logic casAny, accessDone, ackNext, casDrive;

  assign casAny = !loN || !hiN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasLowCnt  <= '0;
      rasHighCnt <= '0;
      casLowCnt  <= '0;
      casHighCnt <= '0;
      colAge     <= '0;
    end else begin
      rasLowCnt  <= rasN   ? '0 : satInc(rasLowCnt);
      rasHighCnt <= rasN   ? satInc(rasHighCnt) : '0;
      casLowCnt  <= casAny ? satInc(casLowCnt) : '0;
      casHighCnt <= casAny ? '0 : satInc(casHighCnt);
      colAge     <= strobe.selCol ? '0 : satInc(colAge);
    end
  end

  always_comb begin
    if (curWrite)
      accessDone = reached(casLowCnt, L_CAS);
    else
      accessDone = reached(casLowCnt, L_CAS) && reached(rasLowCnt, L_RAC) &&
                   reached(casLowCnt, L_CAC) && reached(casLowCnt, L_OE) &&
                   reached(colAge, L_AA);
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    ackNext   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (hostReq && reached(rasHighCnt, L_RP) && reached(casHighCnt, L_CP)) begin
          nextState       = ST_ROWSET;
          strobe.latchReq = 1'b1;
        end
      end
      ST_ROWSET:  nextState = ST_RCDWAIT;
      ST_RCDWAIT: begin
        if (reached(rasLowCnt, L_RCD)) begin
          nextState     = ST_COLSET;
          strobe.selCol = 1'b1;
        end
      end
      ST_COLSET:  nextState = ST_ACCESS;
      ST_ACCESS: begin
        if (accessDone) begin
          nextState      = ST_RELEASE;
          ackNext        = 1'b1;
          strobe.capture = !curWrite;
        end
      end
      ST_RELEASE: begin
        if (reached(rasLowCnt, L_RAS) && reached(rasLowCnt, L_AR))
          nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign casDrive = (nextState == ST_ACCESS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rasN    <= 1'b1;
      loN     <= 1'b1;
      hiN     <= 1'b1;
      weN     <= 1'b1;
      oeN     <= 1'b1;
      dqOe    <= 1'b0;
      hostAck <= 1'b0;
    end else begin
      state   <= nextState;
      rasN    <= (nextState == ST_IDLE) || (nextState == ST_ROWSET);
      loN     <= !(casDrive && laneMask[0]);
      hiN     <= !(casDrive && laneMask[1]);
      weN     <= !(casDrive && curWrite);
      oeN     <= !(casDrive && !curWrite);
      dqOe    <= curWrite && ((nextState == ST_COLSET) || (nextState == ST_ACCESS));
      hostAck <= ackNext;
    end
  end

  // R3
  cas_inside_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    casAny |-> !rasN);

  // R4
  ras_min_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (rasLowCnt >= L_RAS));

  // R8
  col_hold_span_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (rasLowCnt >= L_AR));

  // R5
  ras_precharge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (rasHighCnt >= L_RP));

  // R11
  ras_to_cas_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(casAny) |-> (rasLowCnt >= L_RCD));

  // R6
  read_we_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> weN);

  // R7
  write_with_cas_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(weN) |-> ($rose(casAny) && $past(dqOe)));

  // R9
  bus_write_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> (curWrite && !rasN));

  // R10
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |=> !hostAck);

  // R2
  upper_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hiN |-> laneMask[1]);

endmodule

// File: rtl/bytelane_dram_ctrl.sv
module bytelane_dram_ctrl import bldc_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int T_RAS  = 6,
  parameter int T_RP   = 3,
  parameter int T_CP   = 2,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RAC  = 5,
  parameter int T_CAC  = 2,
  parameter int T_AA   = 3,
  parameter int T_OE   = 2,
  parameter int T_AR   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostReq,
  input  logic                hostWe,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic [DATA_W-1:0]   hostWdata,
  input  logic [1:0]          hostBe,
  output logic                hostAck,
  output logic [DATA_W-1:0]   hostRdata,
  output logic                dramRowStrobeN,
  output logic                dramLoStrobeN,
  output logic                dramHiStrobeN,
  output logic                dramWrEnN,
  output logic                dramOutEnN,
  output logic [ADDR_W/2-1:0] dramAddr,
  output logic [DATA_W-1:0]   dramDqOut,
  output logic                dramDqOe,
  input  logic [DATA_W-1:0]   dramDqIn
);
  dpStrobe_t  strobe;
  logic       curWrite;
  logic [1:0] laneMask;

  bldc_ctrl #(
    .T_RAS(T_RAS), .T_RP(T_RP), .T_CP(T_CP), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_RAC(T_RAC), .T_CAC(T_CAC), .T_AA(T_AA), .T_OE(T_OE), .T_AR(T_AR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .curWrite(curWrite),
    .laneMask(laneMask), .strobe(strobe), .rasN(dramRowStrobeN),
    .loN(dramLoStrobeN), .hiN(dramHiStrobeN), .weN(dramWrEnN),
    .oeN(dramOutEnN), .dqOe(dramDqOe), .hostAck(hostAck)
  );

  bldc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostBe(hostBe),
    .dramDqIn(dramDqIn), .dramAddr(dramAddr), .dramDqOut(dramDqOut),
    .hostRdata(hostRdata), .curWrite(curWrite), .laneMask(laneMask)
  );

  // R1
  col_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dramLoStrobeN || !dramHiStrobeN) |-> $stable(dramAddr));

endmodule

// File: tb/bytelane_dram_ctrl_bench.sv
module bytelane_dram_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T_RAS = 6, T_RP = 3, T_CP = 2, T_RCD = 2, T_CAS = 2;
  localparam int T_RAC = 5, T_CAC = 2, T_AA = 3, T_OE = 2, T_AR = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic hostReq = 1'b0, hostWe = 1'b0;
  logic [15:0] hostAddr = '0, hostWdata = '0;
  logic [1:0] hostBe = '0;
  logic hostAck, dramRowStrobeN, dramLoStrobeN, dramHiStrobeN;
  logic dramWrEnN, dramOutEnN, dramDqOe;
  logic [15:0] hostRdata, dramDqOut, dramDqIn;
  logic [7:0] dramAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  bytelane_dram_ctrl #(
    .T_RAS(T_RAS), .T_RP(T_RP), .T_CP(T_CP), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_RAC(T_RAC), .T_CAC(T_CAC), .T_AA(T_AA), .T_OE(T_OE), .T_AR(T_AR)
  ) u_bytelane_dram_ctrl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostBe(hostBe),
    .hostAck(hostAck), .hostRdata(hostRdata), .dramRowStrobeN(dramRowStrobeN),
    .dramLoStrobeN(dramLoStrobeN), .dramHiStrobeN(dramHiStrobeN),
    .dramWrEnN(dramWrEnN), .dramOutEnN(dramOutEnN), .dramAddr(dramAddr),
    .dramDqOut(dramDqOut), .dramDqOe(dramDqOe), .dramDqIn(dramDqIn)
  );

  int compared = 0, mismatched = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // transaction context set by the host task
  logic [7:0]  expRow = '0, expCol = '0;
  logic [1:0]  expMask = 2'b11;
  logic        txnWe = 1'b0;
  logic [15:0] shadow [256];

  // memory model with per-signal ages counted in clock cycles
  logic [15:0] memArr [256];
  int rasAge = 0, rasHighAge = 0, casAge = 0, casHighAge = 0;
  int oeAge = 0, weAge = 0, dqOeAge = 0, addrAge = 0;
  logic [7:0] prevAddr = '0, latchedRow = '0, latchedCol = '0;
  logic casAnyB, dataValid;
  logic [7:0] memIdx;

  assign casAnyB   = !dramLoStrobeN || !dramHiStrobeN;
  assign dataValid = (rasAge >= T_RAC) && (casAge >= T_CAC) && (oeAge >= T_OE) && (addrAge >= T_AA);
  assign memIdx    = {latchedRow[3:0], latchedCol[3:0]};

  always_comb begin
    dramDqIn = 16'h5AA5;
    if (!dramRowStrobeN && !dramOutEnN && dramWrEnN) begin
      if (!dramLoStrobeN) dramDqIn[7:0]  = dataValid ? memArr[memIdx][7:0]  : 8'hDE;
      if (!dramHiStrobeN) dramDqIn[15:8] = dataValid ? memArr[memIdx][15:8] : 8'hDE;
    end
  end

  always @(negedge clk) begin
    if (!rstN) begin
      rasAge <= 0; rasHighAge <= 0; casAge <= 0; casHighAge <= 0;
      oeAge <= 0; weAge <= 0; dqOeAge <= 0; addrAge <= 0;
    end else begin
      if (!dramRowStrobeN && rasAge == 0) begin
        chk(rasHighAge >= T_RP, "R5 row precharge span", rasHighAge, T_RP);
        chk(dramAddr == expRow, "R1 row at row strobe fall", dramAddr, expRow);
        latchedRow <= dramAddr;
      end
      if (dramRowStrobeN && rasAge != 0) begin
        chk(rasAge >= T_RAS, "R4 row strobe low span", rasAge, T_RAS);
        chk(rasAge >= T_AR, "R8 column hold span", rasAge, T_AR);
        chk(dramAddr == latchedCol, "R1 column held to row strobe rise", dramAddr, latchedCol);
      end
      if (casAnyB) chk(!dramRowStrobeN, "R3 column strobe outside row strobe", dramRowStrobeN, 0);
      if (casAnyB && casAge == 0) begin
        chk(casHighAge >= T_CP, "R5 column precharge span", casHighAge, T_CP);
        chk(rasAge >= T_RCD, "R11 row to column delay", rasAge, T_RCD);
        chk(dramAddr == expCol, "R1 column at column strobe fall", dramAddr, expCol);
        chk({!dramHiStrobeN, !dramLoStrobeN} == expMask, "R2 lane strobes",
            {!dramHiStrobeN, !dramLoStrobeN}, expMask);
        latchedCol <= dramAddr;
        if (txnWe) begin
          chk(!dramWrEnN && weAge == 0, "R7 write enable with column strobe", weAge, 0);
          chk(dramDqOe && dqOeAge >= 1, "R7 data driven before strobe", dqOeAge, 1);
          if (!dramLoStrobeN) memArr[{latchedRow[3:0], dramAddr[3:0]}][7:0]  <= dramDqOut[7:0];
          if (!dramHiStrobeN) memArr[{latchedRow[3:0], dramAddr[3:0]}][15:8] <= dramDqOut[15:8];
        end else begin
          chk(dramWrEnN && !dramOutEnN && oeAge == 0, "R6 output enable with column strobe",
              {dramWrEnN, dramOutEnN}, 2'b10);
        end
      end
      if (dramDqOe) chk(txnWe && !dramRowStrobeN, "R9 bus driven outside write", txnWe, 1);
      rasAge     <= dramRowStrobeN ? 0 : rasAge + 1;
      rasHighAge <= dramRowStrobeN ? rasHighAge + 1 : 0;
      casAge     <= casAnyB ? casAge + 1 : 0;
      casHighAge <= casAnyB ? 0 : casHighAge + 1;
      oeAge      <= !dramOutEnN ? oeAge + 1 : 0;
      weAge      <= !dramWrEnN ? weAge + 1 : 0;
      dqOeAge    <= dramDqOe ? dqOeAge + 1 : 0;
      addrAge    <= (dramAddr != prevAddr) ? 1 : addrAge + 1;
      prevAddr   <= dramAddr;
    end
  end

  task automatic runTxn(input logic we, input logic [7:0] row, input logic [7:0] col,
                        input logic [15:0] wd, input logic [1:0] be);
    logic [1:0] m;
    logic [15:0] ex;
    int wait_n;
    m = (be == 2'b00) ? 2'b11 : be;
    @(negedge clk);
    expRow = row; expCol = col; expMask = m; txnWe = we;
    hostReq = 1'b1; hostWe = we; hostAddr = {row, col}; hostWdata = wd; hostBe = be;
    wait_n = 0;
    do begin
      @(negedge clk);
      wait_n++;
    end while (!hostAck && wait_n < 200);
    chk(hostAck, "R10 acknowledge arrives", hostAck, 1);
    hostReq = 1'b0;
    ex = {m[1] ? shadow[{row[3:0], col[3:0]}][15:8] : 8'h00,
          m[0] ? shadow[{row[3:0], col[3:0]}][7:0]  : 8'h00};
    if (we) begin
      if (m[0]) shadow[{row[3:0], col[3:0]}][7:0]  = wd[7:0];
      if (m[1]) shadow[{row[3:0], col[3:0]}][15:8] = wd[15:8];
    end else begin
      chk(hostRdata == ex, "R6 R10 read word with lane masking", hostRdata, ex);
    end
    @(negedge clk);
    chk(!hostAck, "R10 acknowledge lasts one cycle", hostAck, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      memArr[i] = '0;
      shadow[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(dramRowStrobeN && dramLoStrobeN && dramHiStrobeN && dramWrEnN && dramOutEnN,
        "R3 strobes high in reset", {dramRowStrobeN, dramLoStrobeN, dramHiStrobeN, dramWrEnN, dramOutEnN}, 5'h1F);
    chk(!dramDqOe && !hostAck, "R3 R9 bus and acknowledge idle in reset", {dramDqOe, hostAck}, 0);
    rstN = 1'b1;
    // every address, byte enables cycling through all four codes
    for (int i = 0; i < 256; i++)
      runTxn(1'b1, {4'h0, 4'(i >> 4)}, {4'h0, 4'(i)}, 16'(i * 16'h9E37) ^ 16'h1234, 2'(i));
    for (int i = 0; i < 256; i++)
      runTxn(1'b0, {4'h0, 4'(i >> 4)}, {4'h0, 4'(i)}, 16'h0, 2'(i + 1));
    // corner addresses rewritten per lane, then read as full words (R2)
    for (int k = 0; k < 4; k++) begin
      runTxn(1'b1, 8'h0F * 8'(k & 1), 8'h0F * 8'(k >> 1), 16'hA000 + 16'(k), 2'b01);
      runTxn(1'b1, 8'h0F * 8'(k & 1), 8'h0F * 8'(k >> 1), 16'h00C0 + 16'(k << 12), 2'b10);
      runTxn(1'b0, 8'h0F * 8'(k & 1), 8'h0F * 8'(k >> 1), 16'h0, 2'b00);
      runTxn(1'b0, 8'h0F * 8'(k & 1), 8'h0F * 8'(k >> 1), 16'h0, 2'b10);
    end
    repeat (10) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule